// File: doc/BRIEF.md
# Sixteen-Bit Single-Cycle Processor Core

This block is a small processor that completes one instruction per clock. Words are 16 bits wide, and there are four general registers, r0 to r3. Instruction memory and data memory are separate, and both are addressed by word. In each cycle the core presents its program counter to a combinational instruction ROM. It decodes the returned word and does three things before the next rising edge: it computes a result, writes it back to the register file, and updates the program counter. Loads read a data RAM combinationally. Stores raise a write enable, and the RAM captures the data on the rising edge.

The only output device is a set of display registers that sit outside the core. The display instruction raises a one-cycle strobe and presents a display index and the value of a source register. The external display register captures that value on the clock edge. Instructions are 16 bits wide. A 4-bit opcode sits in bits 15-12 and is followed by 2-bit register fields. The remaining bits hold a function code, an 8-bit immediate or a 12-bit jump target.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0, and `imem_addr` always presents the current program counter.
- R2: Opcode 0 is R-type: rs in bits 11-10, rt in 9-8, rd in 7-6, function in 5-0. Function codes 0..7 write to rd, in order: rs OR rt, rs AND rt, rs+rt, rs-rt, rs<<rt, rs>>rt (logical), rs XOR rt, and 1 if rs<rt as signed numbers (otherwise 0).
- R3: An R-type word whose function code is 8..63 writes no register, writes no memory and raises no display strobe.
- R4: Opcode 2 writes the 8-bit immediate in bits 7-0, shifted left by 8, into rt.
- R5: Opcode 3 writes rs OR the zero-extended immediate into rt.
- R6: Opcode 4 loads into rt the data word at address rs + sign-extended immediate.
- R7: Opcode 5 raises `dmem_we` for one cycle, with `dmem_addr` = rs + sign-extended immediate and `dmem_wdata` = rt. It changes no register.
- R8: Opcode 1 raises `disp_we` for one cycle, with `disp_idx` = the zero-extended immediate and `disp_data` = rs. No other opcode raises `disp_we`.
- R9: Opcode 6 loads the program counter with its current upper 4 bits joined to the 12-bit target in bits 11-0.
- R10: Opcode 7 (beq) moves to PC+1+sign-extended offset when rs equals rt, and otherwise to PC+1. Opcode 8 (bne) uses the inverted test. The word 0x70FF therefore branches to itself.
- R11: Every opcode other than 6, 7 and 8 advances the program counter by exactly 1. This includes opcodes 9..15, which also change no state.
- R12: r0 is an ordinary register that can be written and read back.
- R13: A shift amount of 16 or more, taken from the full rt value, yields 0 for both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Instruction word address (program counter) |
| imem_data | input | 16 | Instruction word from combinational ROM |
| dmem_addr | output | 16 | Data word address for load or store |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store enable, captured by RAM on rising edge |
| dmem_rdata | input | 16 | Combinational load data |
| disp_we | output | 1 | Display register write strobe |
| disp_idx | output | 8 | Display register index |
| disp_data | output | 16 | Value for the selected display register |

## Verification
The bench builds the core with its default 16-bit word and with `STAGED_SHIFT` set to 1. That choice selects the logarithmic shifter, so the shift that crosses every stage is exercised, and so is the shift amount of 16, which must zero the result without wrapping. Results become visible only through display strobes, stores and the fetch address. Skipped paths therefore contain display instructions that must never fire. The signed-compare case uses 0x8000, so an unsigned comparison would give the opposite answer.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
   localparam int OPC_W   = 4;
   localparam int REG_AW  = 2;
   localparam int FUNCT_W = 6;
   localparam int IMM_W   = 8;
   localparam int TGT_W   = 12;
   localparam int ALU_OPS = 8;

   typedef enum logic [OPC_W-1:0] {
      OP_RTYPE = 4'd0,
      OP_DISP  = 4'd1,
      OP_LUI   = 4'd2,
      OP_ORI   = 4'd3,
      OP_LW    = 4'd4,
      OP_SW    = 4'd5,
      OP_JMP   = 4'd6,
      OP_BEQ   = 4'd7,
      OP_BNE   = 4'd8
   } opcode_e;

   typedef enum logic [2:0] {
      ALU_OR, ALU_AND, ALU_ADD, ALU_SUB, ALU_SLL, ALU_SRL, ALU_XOR, ALU_SLT
   } alu_op_e;

   typedef enum logic [1:0] { WB_ALU, WB_LUI, WB_MEM } wb_sel_e;

   typedef enum logic [1:0] { PCN_SEQ, PCN_JMP, PCN_BEQ, PCN_BNE } pc_sel_e;

   typedef struct packed {
      logic    reg_we;
      logic    dst_rd;
      alu_op_e alu_op;
      logic    b_imm;
      logic    imm_sext;
      wb_sel_e wb_sel;
      logic    mem_we;
      logic    disp_we;
      pc_sel_e pc_sel;
   } ctrl_t;
endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
   import cpu16_pkg::*;
(
   input  logic [OPC_W-1:0]   opcode,
   input  logic [FUNCT_W-1:0] funct,
   output ctrl_t              ctrl
);
   always_comb begin
      ctrl          = '0;
      ctrl.alu_op   = ALU_OR;
      ctrl.wb_sel   = WB_ALU;
      ctrl.pc_sel   = PCN_SEQ;
      case (opcode)
         OP_RTYPE: begin
            if (funct < FUNCT_W'(ALU_OPS)) begin
               ctrl.reg_we = 1'b1;
               ctrl.dst_rd = 1'b1;
               ctrl.alu_op = alu_op_e'(funct[2:0]);
            end
         end
         OP_DISP: ctrl.disp_we = 1'b1;
         OP_LUI: begin
            ctrl.reg_we = 1'b1;
            ctrl.wb_sel = WB_LUI;
         end
         OP_ORI: begin
            ctrl.reg_we = 1'b1;
            ctrl.b_imm  = 1'b1;
         end
         OP_LW: begin
            ctrl.reg_we   = 1'b1;
            ctrl.b_imm    = 1'b1;
            ctrl.imm_sext = 1'b1;
            ctrl.alu_op   = ALU_ADD;
            ctrl.wb_sel   = WB_MEM;
         end
         OP_SW: begin
            ctrl.mem_we   = 1'b1;
            ctrl.b_imm    = 1'b1;
            ctrl.imm_sext = 1'b1;
            ctrl.alu_op   = ALU_ADD;
         end
         OP_JMP: ctrl.pc_sel = PCN_JMP;
         OP_BEQ: begin
            ctrl.pc_sel   = PCN_BEQ;
            ctrl.imm_sext = 1'b1;
         end
         OP_BNE: begin
            ctrl.pc_sel   = PCN_BNE;
            ctrl.imm_sext = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
   parameter int W  = 16,
   parameter int AW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra,
   input  logic [AW-1:0] rb,
   output logic [W-1:0]  qa,
   output logic [W-1:0]  qb
);
   localparam int N = 1 << AW;

   if (W < 1 || AW < 1) begin : g_bad_cfg
      $error("cpu16_regfile: W and AW must be positive");
   end

   logic [W-1:0] regs [N];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) regs[i] <= '0;
      end else if (we) begin
         regs[wa] <= wd;
      end
   end

   assign qa = regs[ra];
   assign qb = regs[rb];
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
   import cpu16_pkg::*;
#(
   parameter int W            = 16,
   parameter bit STAGED_SHIFT = 1'b1
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   localparam int SH_W = $clog2(W);

   if (W < 4 || (1 << SH_W) != W) begin : g_bad_w
      $error("cpu16_alu: W must be a power of two of at least 4");
   end

   logic         over;
   logic [W-1:0] shl, shr;

   assign over = |b[W-1:SH_W];

   if (STAGED_SHIFT) begin : g_staged
      logic [W-1:0] sl [SH_W+1];
      logic [W-1:0] sr [SH_W+1];
      assign sl[0] = a;
      assign sr[0] = a;
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         assign sl[k+1] = b[k] ? (sl[k] << (1 << k)) : sl[k];
         assign sr[k+1] = b[k] ? (sr[k] >> (1 << k)) : sr[k];
      end
      assign shl = over ? '0 : sl[SH_W];
      assign shr = over ? '0 : sr[SH_W];
   end else begin : g_flat
      assign shl = over ? '0 : (a << b[SH_W-1:0]);
      assign shr = over ? '0 : (a >> b[SH_W-1:0]);
   end

   always_comb begin
      unique case (op)
         ALU_OR:  y = a | b;
         ALU_AND: y = a & b;
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_SLL: y = shl;
         ALU_SRL: y = shr;
         ALU_XOR: y = a ^ b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
   import cpu16_pkg::*;
#(
   parameter int WORD_W       = 16,
   parameter bit STAGED_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [WORD_W-1:0] imem_addr,
   input  logic [WORD_W-1:0] imem_data,
   output logic [WORD_W-1:0] dmem_addr,
   output logic [WORD_W-1:0] dmem_wdata,
   output logic              dmem_we,
   input  logic [WORD_W-1:0] dmem_rdata,
   output logic              disp_we,
   output logic [IMM_W-1:0]  disp_idx,
   output logic [WORD_W-1:0] disp_data
);
   localparam int HI_W = WORD_W - TGT_W;

   if (WORD_W != 16) begin : g_bad_word
      $error("cpu16_core: instruction encoding fixes WORD_W at 16");
   end

   logic [WORD_W-1:0]  pc, pc_next, pc_inc, br_tgt, jmp_tgt;
   logic [OPC_W-1:0]   f_opc;
   logic [REG_AW-1:0]  f_rs, f_rt, f_rd, w_addr;
   logic [FUNCT_W-1:0] f_funct;
   logic [IMM_W-1:0]   f_imm;
   logic [TGT_W-1:0]   f_tgt;
   logic [WORD_W-1:0]  imm_ext, rs_val, rt_val, alu_b, alu_y, wb_val;
   logic               rs_eq_rt;
   ctrl_t              ctrl;

   assign f_opc   = imem_data[WORD_W-1 -: OPC_W];
   assign f_rs    = imem_data[11:10];
   assign f_rt    = imem_data[9:8];
   assign f_rd    = imem_data[7:6];
   assign f_funct = imem_data[FUNCT_W-1:0];
   assign f_imm   = imem_data[IMM_W-1:0];
   assign f_tgt   = imem_data[TGT_W-1:0];

   cpu16_decode u_dec (
      .opcode (f_opc),
      .funct  (f_funct),
      .ctrl   (ctrl)
   );

   assign imm_ext = ctrl.imm_sext ? {{(WORD_W-IMM_W){f_imm[IMM_W-1]}}, f_imm}
                                  : {{(WORD_W-IMM_W){1'b0}}, f_imm};
   assign w_addr  = ctrl.dst_rd ? f_rd : f_rt;

   cpu16_regfile #(.W(WORD_W), .AW(REG_AW)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (ctrl.reg_we),
      .wa  (w_addr),
      .wd  (wb_val),
      .ra  (f_rs),
      .rb  (f_rt),
      .qa  (rs_val),
      .qb  (rt_val)
   );

   assign alu_b = ctrl.b_imm ? imm_ext : rt_val;

   cpu16_alu #(.W(WORD_W), .STAGED_SHIFT(STAGED_SHIFT)) u_alu (
      .op (ctrl.alu_op),
      .a  (rs_val),
      .b  (alu_b),
      .y  (alu_y)
   );

   always_comb begin
      unique case (ctrl.wb_sel)
         WB_LUI:  wb_val = {f_imm, {(WORD_W-IMM_W){1'b0}}};
         WB_MEM:  wb_val = dmem_rdata;
         default: wb_val = alu_y;
      endcase
   end

   assign rs_eq_rt = (rs_val == rt_val);
   assign pc_inc   = pc + WORD_W'(1);
   assign br_tgt   = pc_inc + imm_ext;
   assign jmp_tgt  = {pc[WORD_W-1 -: HI_W], f_tgt};

   always_comb begin
      unique case (ctrl.pc_sel)
         PCN_JMP: pc_next = jmp_tgt;
         PCN_BEQ: pc_next = rs_eq_rt ? br_tgt : pc_inc;
         PCN_BNE: pc_next = rs_eq_rt ? pc_inc : br_tgt;
         default: pc_next = pc_inc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc <= '0;
      else     pc <= pc_next;
   end

   assign imem_addr  = pc;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rt_val;
   assign dmem_we    = ctrl.mem_we;
   assign disp_we    = ctrl.disp_we;
   assign disp_idx   = f_imm;
   assign disp_data  = rs_val;
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk (
   input logic        clk,
   input logic        rst,
   input logic [15:0] imem_addr,
   input logic [15:0] imem_data,
   input logic        dmem_we,
   input logic        disp_we,
   input logic [7:0]  disp_idx
);
   logic [3:0] opc;
   assign opc = imem_data[15:12];

   // R1
   pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (imem_addr == 16'h0000));

   // R11
   seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
      (opc <= 4'd5 || opc >= 4'd9) |=> (imem_addr == $past(imem_addr) + 16'd1));

   // R9
   jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
      (opc == 4'd6) |=> (imem_addr == {$past(imem_addr[15:12]), $past(imem_data[11:0])}));

   // R10
   self_branch_chk: assert property (@(posedge clk) disable iff (rst)
      (imem_data == 16'h70FF) |=> $stable(imem_addr));

   // R7
   store_only_chk: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> (opc == 4'd5));

   // R8
   disp_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      disp_we |-> (opc == 4'd1 && disp_idx == imem_data[7:0]));
endmodule

bind cpu16_core cpu16_core_chk u_chk (.*);

// File: tb/cpu16_core_tb.sv
module cpu16_core_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, disp_data;
   logic        dmem_we, disp_we;
   logic [7:0]  disp_idx;

   logic [15:0] imem [64];
   logic [15:0] dmem [256];
   int          checks = 0;
   int          fails  = 0;
   int          dmem_writes = 0;
   int          pc_w = 0;
   int          halt_at = 0;
   logic [7:0]  q_idx [$];
   logic [15:0] q_data [$];
   string       q_tag [$];

   always #5 clk = ~clk;

   cpu16_core #(.WORD_W(16), .STAGED_SHIFT(1'b1)) u_dut (
      .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
      .dmem_rdata(dmem_rdata), .disp_we(disp_we), .disp_idx(disp_idx),
      .disp_data(disp_data)
   );

   assign imem_data  = imem[imem_addr[5:0]];
   assign dmem_rdata = dmem[dmem_addr[7:0]];

   always @(posedge clk) begin
      if (dmem_we) begin
         dmem[dmem_addr[7:0]] <= dmem_wdata;
         dmem_writes <= dmem_writes + 1;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] rt_w(int rs, int rt, int rd, int fn);
      return {4'h0, 2'(rs), 2'(rt), 2'(rd), 6'(fn)};
   endfunction

   function automatic logic [15:0] it_w(int op, int rs, int rt, int imm);
      return {4'(op), 2'(rs), 2'(rt), 8'(imm)};
   endfunction

   task automatic put(logic [15:0] w);
      imem[pc_w] = w;
      pc_w++;
   endtask

   // driver side of the scoreboard: expected display events
   task automatic put_disp(int rs, int idx, logic [15:0] val, string tag);
      put(it_w(1, rs, 0, idx));
      q_idx.push_back(8'(idx));
      q_data.push_back(val);
      q_tag.push_back(tag);
   endtask

   // monitor side: every strobe must match the next expected item
   always @(negedge clk) begin
      if (!rst && disp_we) begin
         if (q_idx.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R8 unexpected strobe actual=%h:%h expected=none", disp_idx, disp_data);
         end else begin
            chk(q_tag.pop_front(), {8'h0, disp_idx, disp_data},
                {8'h0, q_idx.pop_front(), q_data.pop_front()});
            void'(q_data.size());
         end
      end
   end

   initial begin
      int a;
      for (int i = 0; i < 64; i++) imem[i] = 16'hF000;
      for (int i = 0; i < 256; i++) dmem[i] = 16'h0000;
      dmem[14] = 16'hBEEF;

      put(it_w(2, 0, 0, 8'h12));                 // lui r0
      put_disp(0, 20, 16'h1200, "R4 lui");
      put(it_w(3, 0, 0, 8'h34));                 // ori r0
      put_disp(0, 0, 16'h1234, "R5 ori");
      put(it_w(2, 0, 1, 8'h00));
      put(it_w(3, 1, 1, 8'h05));                 // r1 = 5
      put(rt_w(0, 1, 2, 2));  put_disp(2, 1, 16'h1239, "R2 add");
      put(rt_w(1, 0, 2, 3));  put_disp(2, 2, 16'hEDD1, "R2 sub");
      put(rt_w(0, 1, 2, 1));  put_disp(2, 3, 16'h0004, "R2 and");
      put(rt_w(0, 1, 2, 0));  put_disp(2, 4, 16'h1235, "R2 or");
      put(rt_w(0, 0, 2, 6));  put_disp(2, 5, 16'h0000, "R2 xor");
      put(rt_w(0, 1, 2, 4));  put_disp(2, 6, 16'h4680, "R2 sllv");
      put(rt_w(0, 1, 2, 5));  put_disp(2, 7, 16'h0091, "R2 srlv");
      put(rt_w(1, 0, 2, 7));  put_disp(2, 8, 16'h0001, "R2 slt true");
      put(it_w(2, 0, 3, 8'h80));                 // r3 = 0x8000
      put(rt_w(3, 1, 2, 7));  put_disp(2, 9, 16'h0001, "R2 slt signed");
      put(rt_w(1, 3, 2, 7));  put_disp(2, 10, 16'h0000, "R2 slt false");
      put(rt_w(0, 1, 2, 8));  put_disp(2, 11, 16'h0000, "R3 funct 8 ignored");
      put(it_w(2, 0, 1, 8'h00));
      put(it_w(3, 1, 1, 8'h10));                 // r1 = 16
      put(rt_w(0, 1, 3, 4));  put_disp(3, 12, 16'h0000, "R13 shift by 16");
      put(it_w(5, 1, 0, 8'h02));                 // sw r0 -> 18
      put(it_w(4, 1, 2, 8'hFE));  put_disp(2, 13, 16'hBEEF, "R6 lw negative offset");
      put(it_w(4, 1, 3, 8'h02));  put_disp(3, 14, 16'h1234, "R7 stored word read back");
      put(16'h9FFF);
      put(16'hF0C0);                             // R11 opcodes 9..15
      put(rt_w(0, 0, 0, 6));  put_disp(0, 21, 16'h0000, "R12 r0 written");
      put(it_w(7, 0, 1, 8'h02));                 // beq not taken
      put_disp(0, 15, 16'h0000, "R10 beq fall-through");
      put_disp(1, 16, 16'h0010, "R10 beq fall-through 2");
      put(it_w(8, 0, 1, 8'h01));                 // bne taken
      put(it_w(1, 1, 0, 22));                    // skipped
      put_disp(1, 17, 16'h0010, "R10 bne target");
      a = pc_w;
      put({4'h6, 12'(a + 3)});                   // R9 jump
      put(it_w(1, 1, 0, 23));
      put(it_w(1, 1, 0, 23));
      put_disp(1, 19, 16'h0010, "R9 jump target");
      halt_at = pc_w;
      put(16'h70FF);

      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 reset pc", 32'(imem_addr), 32'h0);
      chk("R8 no strobe in reset", 32'(disp_we), 32'h0);
      rst = 1'b0;

      begin
         int n = 0;
         while (imem_addr != 16'(halt_at) && n < 2000) begin
            @(negedge clk);
            n++;
         end
         if (n >= 2000) chk("R10 watchdog reached halt", 32'(imem_addr), 32'(halt_at));
      end
      repeat (5) @(negedge clk);
      chk("R10 halt holds pc", 32'(imem_addr), 32'(halt_at));
      chk("R8 all strobes seen", 32'(q_idx.size()), 32'h0);
      chk("R7 store data", 32'(dmem[18]), 32'h1234);
      chk("R7 single store", 32'(dmem_writes), 32'h1);
      chk("R6 load source untouched", 32'(dmem[14]), 32'hBEEF);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule